// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of boundary scan cells that sits around the parallel pins of a memory device's I/O ring. Each cell has two flops. A capture/shift flop is clocked on the rising test-clock edge. An update latch is loaded on the falling test-clock edge. The chain forms the serial path between `tdi` and `tdo`. A separate TAP controller supplies the Capture-DR, Shift-DR and Update-DR strobes, together with three decoded mode lines: external test, sample/preload and sample-with-high-Z.

In Capture-DR the chain takes a snapshot of the pins. The same Shift-DR pass then moves that snapshot out while a new preload pattern moves in. Update-DR copies the pattern into the update latches. The latched pattern reaches the pins only under external test. In that mode one dedicated control cell, rather than the functional enable, decides whether the whole output bus drives or floats. Under sample-with-high-Z the bus is floated outright. With no test mode active, the functional outputs and enable reach the pins with no added state.

Top module: `bscan_chain`

## Requirements
- R1: While any test mode is active, a cycle with `captureDr` high loads every chain bit i with `pinIn[i]` at the rising clock edge. Capture takes precedence over shift.
- R2: While any test mode is active, a cycle with `shiftDr` high and `captureDr` low moves the chain one place toward bit 0. `tdi` enters bit CHAIN_LEN-1, and `tdo` always shows chain bit 0.
- R3: With no test mode active, the capture and shift strobes leave the chain unchanged.
- R4: The update latches load the whole chain at the falling clock edge of a cycle with `updateDr` high and a test mode active. At every other time they hold, including during capture and shift.
- R5: Under sample/preload, one Shift-DR pass moves the captured snapshot out on `tdo` while the preload pattern moves in. The pins keep showing `funcOut` and `funcOe` throughout.
- R6: Under external test, `pinOut` equals the update latches, and `funcOut` has no effect on the pins.
- R7: Under external test, `pinOe` equals update latch bit TRI_CELL (default 89), where 1 drives the bus and 0 floats it. `funcOe` has no effect in this mode.
- R8: Under sample-with-high-Z, `pinOe` is 0 while the chain still captures, shifts and updates. This mode takes precedence over external test.
- R9: With no test mode active, `pinOut` equals `funcOut` and `pinOe` equals `funcOe` in the same cycle.
- R10: An active-low `rstN` clears the chain and the update latches at once, so `tdo` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low test logic reset |
| captureDr | input | 1 | Capture-DR strobe |
| shiftDr | input | 1 | Shift-DR strobe |
| updateDr | input | 1 | Update-DR strobe, acted on at the falling edge |
| modeExtest | input | 1 | External test mode decoded |
| modeSamplePre | input | 1 | Sample/preload mode decoded |
| modeSampleZ | input | 1 | Sample with output bus floated |
| tdi | input | 1 | Serial data in |
| pinIn | input | CHAIN_LEN | Values present on the I/O ring pins |
| funcOut | input | CHAIN_LEN | Functional output values from the core |
| funcOe | input | 1 | Functional output bus enable |
| tdo | output | 1 | Serial data out (chain bit 0) |
| pinOut | output | CHAIN_LEN | Values driven toward the pins |
| pinOe | output | 1 | Output bus enable, 0 means high impedance |

## Verification
`pinOut` and `pinOe` are combinational on the mode lines. They also depend on update latches that change at the falling edge, half a cycle after a strobe is presented. Chain contents, and therefore `tdo`, change one rising edge after a capture or shift strobe. The bench drives inputs 1 ns after a rising edge and compares all three outputs 4 ns after it, once the falling-edge update has settled. The reference model applies the update before that comparison and applies capture or shift only after it, so each result is checked in the exact cycle it becomes due.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  // Strobes handed from the control decode to the cell datapath
  typedef struct packed {
    logic capture;     // load pins into chain
    logic shift;       // move chain toward bit 0
    logic update;      // copy chain into update latches (falling edge)
    logic driveLatch;  // pins take update-latch values
    logic forceHiZ;    // output bus floated unconditionally
  } scanStrobes_t;

endpackage

// File: rtl/bscan_ctrl.sv
`timescale 1ns/1ps
module bscan_ctrl (
  input  logic                    captureDr,
  input  logic                    shiftDr,
  input  logic                    updateDr,
  input  logic                    modeExtest,
  input  logic                    modeSamplePre,
  input  logic                    modeSampleZ,
  output bscan_pkg::scanStrobes_t strobes
);

  logic chainSel;

  always_comb begin
    chainSel           = modeExtest | modeSamplePre | modeSampleZ;
    strobes.capture    = captureDr & chainSel;
    // capture wins if both strobes coincide
    strobes.shift      = shiftDr & chainSel & ~captureDr;
    strobes.update     = updateDr & chainSel;
    // floating the bus outranks driving latched data
    strobes.driveLatch = modeExtest & ~modeSampleZ;
    strobes.forceHiZ   = modeSampleZ;
  end

endmodule

// File: rtl/bscan_cells.sv
`timescale 1ns/1ps
module bscan_cells #(
  parameter int CHAIN_LEN = 96,
  parameter int TRI_CELL  = 89
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bscan_pkg::scanStrobes_t strobes,
  input  logic                    tdi,
  input  logic [CHAIN_LEN-1:0]    pinIn,
  input  logic [CHAIN_LEN-1:0]    funcOut,
  input  logic                    funcOe,
  output logic                    tdo,
  output logic [CHAIN_LEN-1:0]    pinOut,
  output logic                    pinOe,
  output logic [CHAIN_LEN-1:0]    shiftState,
  output logic [CHAIN_LEN-1:0]    latchState
);

  localparam int MsbIdx = CHAIN_LEN - 1;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic serialIn;
    logic capQ;
    logic updQ;

    if (i == MsbIdx) begin : g_head
      assign serialIn = tdi;
    end else begin : g_body
      assign serialIn = shiftState[i+1];
    end

    // capture/shift stage, rising edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                capQ <= 1'b0;
      else if (strobes.capture) capQ <= pinIn[i];
      else if (strobes.shift)   capQ <= serialIn;
    end

    // update latch, falling edge
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN)               updQ <= 1'b0;
      else if (strobes.update) updQ <= capQ;
    end

    assign shiftState[i] = capQ;
    assign latchState[i] = updQ;
    assign pinOut[i]     = strobes.driveLatch ? updQ : funcOut[i];
  end

  assign tdo = shiftState[0];

  always_comb begin
    if (strobes.forceHiZ)        pinOe = 1'b0;
    else if (strobes.driveLatch) pinOe = latchState[TRI_CELL];
    else                         pinOe = funcOe;
  end

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain #(
  parameter int CHAIN_LEN = 96,
  parameter int TRI_CELL  = 89
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 captureDr,
  input  logic                 shiftDr,
  input  logic                 updateDr,
  input  logic                 modeExtest,
  input  logic                 modeSamplePre,
  input  logic                 modeSampleZ,
  input  logic                 tdi,
  input  logic [CHAIN_LEN-1:0] pinIn,
  input  logic [CHAIN_LEN-1:0] funcOut,
  input  logic                 funcOe,
  output logic                 tdo,
  output logic [CHAIN_LEN-1:0] pinOut,
  output logic                 pinOe
);

  bscan_pkg::scanStrobes_t strobes;
  logic [CHAIN_LEN-1:0]    shiftState;
  logic [CHAIN_LEN-1:0]    latchState;

  bscan_ctrl i_ctrl (
    .captureDr     (captureDr),
    .shiftDr       (shiftDr),
    .updateDr      (updateDr),
    .modeExtest    (modeExtest),
    .modeSamplePre (modeSamplePre),
    .modeSampleZ   (modeSampleZ),
    .strobes       (strobes)
  );

  bscan_cells #(
    .CHAIN_LEN (CHAIN_LEN),
    .TRI_CELL  (TRI_CELL)
  ) i_cells (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tdi        (tdi),
    .pinIn      (pinIn),
    .funcOut    (funcOut),
    .funcOe     (funcOe),
    .tdo        (tdo),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .shiftState (shiftState),
    .latchState (latchState)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
`timescale 1ns/1ps
module bscan_chain_chk #(
  parameter int CHAIN_LEN = 96,
  parameter int TRI_CELL  = 89
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 captureDr,
  input logic                 shiftDr,
  input logic                 updateDr,
  input logic                 modeExtest,
  input logic                 modeSamplePre,
  input logic                 modeSampleZ,
  input logic                 tdi,
  input logic [CHAIN_LEN-1:0] pinIn,
  input logic [CHAIN_LEN-1:0] funcOut,
  input logic                 funcOe,
  input logic                 tdo,
  input logic [CHAIN_LEN-1:0] pinOut,
  input logic                 pinOe,
  input logic [CHAIN_LEN-1:0] shiftState,
  input logic [CHAIN_LEN-1:0] latchState
);

  logic anyMode;
  assign anyMode = modeExtest | modeSamplePre | modeSampleZ;

  // R1
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMode && captureDr |=> shiftState == $past(pinIn));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMode && shiftDr && !captureDr |=> shiftState[CHAIN_LEN-1] == $past(tdi));

  // R2
  shift_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMode && shiftDr && !captureDr |=> tdo == $past(shiftState[1]));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyMode |=> $stable(shiftState));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(updateDr && anyMode) |-> $stable(latchState));

  // R5
  preload_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSamplePre && !modeExtest && !modeSampleZ |-> pinOut == funcOut && pinOe == funcOe);

  // R6
  extest_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeExtest && !modeSampleZ |-> pinOut == latchState);

  // R7
  tri_cell_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeExtest && !modeSampleZ |-> pinOe == latchState[TRI_CELL]);

  // R8
  samplez_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSampleZ |-> !pinOe);

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyMode |-> pinOut == funcOut && pinOe == funcOe);

endmodule

bind bscan_chain bscan_chain_chk #(
  .CHAIN_LEN (CHAIN_LEN),
  .TRI_CELL  (TRI_CELL)
) i_chk (.*);

// File: tb/test_bscan_chain.sv
`timescale 1ns/1ps
module test_bscan_chain;

  localparam int N   = 96;
  localparam int TRI = 89;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic         modeExtest = 1'b0, modeSamplePre = 1'b0, modeSampleZ = 1'b0;
  logic         tdi = 1'b0;
  logic [N-1:0] pinIn = '0, funcOut = '0;
  logic         funcOe = 1'b1;
  logic         tdo, pinOe;
  logic [N-1:0] pinOut;

  bscan_chain #(.CHAIN_LEN(N), .TRI_CELL(TRI)) i_bscan_chain (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .modeExtest(modeExtest), .modeSamplePre(modeSamplePre),
    .modeSampleZ(modeSampleZ), .tdi(tdi), .pinIn(pinIn), .funcOut(funcOut),
    .funcOe(funcOe), .tdo(tdo), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #2.5 clk = ~clk;

  int    nVec = 0;
  int    nMiss = 0;
  bit    done = 1'b0;
  string phaseTag = "R10";

  // next values of the slow inputs, applied at the drive point
  logic         nRst = 1'b0;
  logic [N-1:0] nIn = '0, nFunc = '0;
  logic         nOe = 1'b1;

  // reference model: queue front = bit 0 (tdo side)
  bit           refChain[$];
  logic [N-1:0] refLatch = '0;

  function automatic logic [N-1:0] chainVec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = refChain[i];
    return v;
  endfunction

  function automatic logic [N-1:0] rndVec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom % 2);
    return v;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nMiss++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic step(bit cap, bit sh, bit up, bit ex, bit sp, bit sz, bit din);
    bit sel;
    @(posedge clk);
    #1;
    rstN = nRst; pinIn = nIn; funcOut = nFunc; funcOe = nOe;
    captureDr = cap; shiftDr = sh; updateDr = up;
    modeExtest = ex; modeSamplePre = sp; modeSampleZ = sz; tdi = din;
    #3;
    sel = ex | sp | sz;
    if (!nRst) begin
      refChain.delete();
      for (int i = 0; i < N; i++) refChain.push_back(1'b0);
      refLatch = '0;
    end else if (up && sel) begin
      refLatch = chainVec();
    end
    // outputs due this cycle
    check(sz ? "R8" : ex ? "R6" : sp ? "R5" : nRst ? "R9" : "R10",
          pinOut, (ex && !sz) ? refLatch : funcOut);
    check(sz ? "R8" : ex ? "R7" : sp ? "R5" : nRst ? "R9" : "R10",
          N'(pinOe), N'(sz ? 1'b0 : ex ? refLatch[TRI] : funcOe));
    check(phaseTag, N'(tdo), N'(refChain[0]));
    // state for next rising edge
    if (nRst && sel) begin
      if (cap) begin
        for (int i = 0; i < N; i++) refChain[i] = pinIn[i];
      end else if (sh) begin
        void'(refChain.pop_front());
        refChain.push_back(din);
      end
    end
  endtask

  initial begin
    logic [N-1:0] pre;
    for (int i = 0; i < N; i++) refChain.push_back(1'b0);
    nFunc = rndVec(); nIn = rndVec(); nOe = 1'b1;

    // R10: held in reset, chain and latches clear
    phaseTag = "R10"; nRst = 1'b0;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);

    // R9: pass-through with changing functional values
    phaseTag = "R9"; nRst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      nFunc = rndVec(); nOe = k[0];
      step(0, 0, 0, 0, 0, 0, 0);
    end
    nOe = 1'b1;

    // R1: capture under sample/preload
    phaseTag = "R1"; nIn = rndVec();
    step(1, 0, 0, 0, 1, 0, 0);
    // R5: snapshot out, preload in, one pass; pins changing is ignored
    phaseTag = "R5"; pre = rndVec(); pre[TRI] = 1'b1;
    for (int i = 0; i < N; i++) begin
      nIn = rndVec(); nFunc = rndVec();
      step(0, 1, 0, 0, 1, 0, pre[i]);
    end
    // R4: latch loads on update only
    phaseTag = "R4";
    step(0, 0, 1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);

    // R6/R7: external test drives latches, bus enabled by control cell
    phaseTag = "R6";
    for (int k = 0; k < 3; k++) begin
      nFunc = rndVec(); nOe = k[0];
      step(0, 0, 0, 1, 0, 0, 0);
    end
    phaseTag = "R2"; nIn = rndVec();
    step(1, 0, 0, 1, 0, 0, 0);
    pre = rndVec(); pre[TRI] = 1'b0;
    for (int i = 0; i < N; i++) step(0, 1, 0, 1, 0, 0, pre[i]);
    phaseTag = "R7";
    step(0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);

    // R3: strobes with no mode leave chain and latches alone
    phaseTag = "R3"; nIn = rndVec();
    step(1, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) step(0, 1, 1, 0, 0, 0, 1);
    phaseTag = "R4";
    step(0, 0, 0, 1, 0, 0, 0);
    phaseTag = "R2";
    for (int k = 0; k < 8; k++) step(0, 1, 0, 1, 0, 0, 1'(k % 3 == 0));

    // R8: sample-with-high-Z floats bus yet chain still works
    phaseTag = "R8"; nIn = rndVec(); nIn[TRI] = 1'b1;
    step(1, 0, 0, 0, 0, 1, 0);
    step(0, 0, 1, 1, 0, 1, 0);
    for (int k = 0; k < N / 2; k++) step(0, 1, 0, 0, 0, 1, 1'(k % 2));
    step(0, 0, 0, 1, 0, 0, 0);

    // R10: reset in external test clears latches at once
    phaseTag = "R10"; nRst = 1'b0;
    step(0, 0, 0, 1, 0, 0, 0);
    nRst = 1'b1;
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nMiss++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
      $finish;
    end
  end

endmodule